// File: doc/BRIEF.md
# Interrupt Route Map Decoder

This block keeps the routing state of an external interrupt controller. A core-map bank holds one byte-wide routing field per interrupt line, four fields to a 32-bit word. A pin-map bank holds one byte per group of 32 lines. Both are written over a simple 32-bit register bus. The block decodes each field into a target core index for every line and into a parent pin index for every group, and presents the decoded values as flat vectors. A neighbouring aggregator, which holds the pending state and drives the parent pins, consumes these vectors.

A core-map field normally uses one-hot style decoding: the position of the lowest set bit, with anything at 4 or above falling back to core 0. When the encoded-core bit of the configuration register is set, the byte is taken literally as the core number. If a write moves a line whose raw pending input is high, the block does not switch the line's core silently. Instead it issues one move request per cycle, each carrying the line, the old core and the new core, and holds `busy` while requests remain. The decoded core of that line changes in the same cycle edge that retires its request, so the aggregator can drop the line at the old core and raise it at the new one.

The configuration register can only take a nonzero value while the controller-enable bit is clear. Its stored value is always masked by a read-only feature word.

Top module: `irq_route_map`

## Requirements
- R1: After reset the configuration register reads 0, `busy` is low, and every decoded core and pin is 0.
- R2: With encoded-core mode off (configuration bit 1 clear), a core-map byte decodes to the index of its lowest set bit. A byte whose lowest set bit is at position 4 or higher, or a zero byte, decodes to core 0. Byte i of core-map word w (addresses from CMAP_BASE) routes line 4*w+i.
- R3: With encoded-core mode on (configuration bit 1 set), the written byte value itself becomes the line's core number. Decoding uses the mode in force at the time of the write.
- R4: A pin-map byte j of word p (addresses from 2) sets the pin of group 4*p+j to the index of its lowest set bit, or to 0 when that index is 4 or more or the byte is zero. A pin-map write never raises `busy`.
- R5: A core-map write stores the raw word, readable at the same address. A changed field whose line's pending input is low takes its new core at the write edge.
- R6: For each changed field whose line is pending at the write, the block raises `busy` with a move request (`mv_valid`, `mv_line`, `mv_old`, `mv_new`). Requests go out in ascending field order, one per cycle. A line's decoded core switches from `mv_old` to `mv_new` at the edge that ends its request.
- R7: A field whose decoded value does not change produces no move request.
- R8: Address 0 reads the feature mask. A write to it is rejected: `bus_err` pulses high in the cycle after the write edge.
- R9: An accepted write to the configuration register (address 1) stores the written data ANDed with the feature mask. Bit 0 is controller enable.
- R10: While controller enable is set, a nonzero configuration write is rejected with `bus_err` and leaves the register unchanged. A zero write is always accepted.
- R11: Any write issued while `busy` is high is rejected with `bus_err` and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bus_err | output | 1 | Rejected-write response, one cycle after the write edge |
| line_pend | input | N_LINES | Raw pending state of each line |
| line_core | output | N_LINES*8 | Decoded core for each line, 8 bits per line |
| grp_pin | output | GROUPS*2 | Decoded parent pin for each 32-line group |
| busy | output | 1 | Move requests outstanding |
| mv_valid | output | 1 | A move request is presented this cycle |
| mv_line | output | LINE_W | Line being moved |
| mv_old | output | 8 | Core the line leaves |
| mv_new | output | 8 | Core the line joins |

## Verification
The bench walks a table of routing bytes through both decode modes. The table covers out-of-range high bits, the zero byte, and bytes with several bits set. A decoder that picked the highest set bit, or that skipped the fallback, would route those lines to the wrong core. Migration is checked on a word with mixed pending and non-pending fields. A design that switched pending lines at once would show the new core one or two cycles early. A design that moved idle lines, or moved unchanged fields, would raise `busy` or a request where none is due. The configuration guard is checked by enabling the controller and attempting a mode write: a missing guard would let the mode bit land. A write issued mid-migration must bounce instead of being applied.

// File: rtl/irq_route_map.sv
module irq_route_map #(
  parameter int N_LINES = 64,
  parameter int ADDR_W = 8,
  parameter logic [31:0] FEATURE_MASK = 32'h3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_err,
  input  logic [N_LINES-1:0]    line_pend,
  output logic [N_LINES*8-1:0]  line_core,
  output logic [((N_LINES+31)/32)*2-1:0] grp_pin,
  output logic                  busy,
  output logic                  mv_valid,
  output logic [$clog2(N_LINES)-1:0] mv_line,
  output logic [7:0]            mv_old,
  output logic [7:0]            mv_new
);
  localparam int GROUPS     = (N_LINES + 31) / 32;
  localparam int PIN_WORDS  = (GROUPS + 3) / 4;
  localparam int CMAP_WORDS = N_LINES / 4;
  localparam int LINE_W     = $clog2(N_LINES);
  localparam int WIDX_W     = (CMAP_WORDS > 1) ? $clog2(CMAP_WORDS) : 1;
  localparam int A_FEAT     = 0;
  localparam int A_CFG      = 1;
  localparam int A_PIN0     = 2;
  localparam int A_CMAP0    = A_PIN0 + PIN_WORDS;
  localparam int EN_BIT     = 0;
  localparam int ENC_BIT    = 1;

  function automatic logic [7:0] low_bit_dec(input logic [7:0] b);
    if (b[0])      return 8'd0;
    else if (b[1]) return 8'd1;
    else if (b[2]) return 8'd2;
    else if (b[3]) return 8'd3;
    else           return 8'd0;
  endfunction

  logic [31:0] cfg_q;
  logic [31:0] cmap_raw [CMAP_WORDS];
  logic [31:0] pin_raw  [PIN_WORDS];
  logic [7:0]  core_q   [N_LINES];
  logic [1:0]  pin_q    [GROUPS];
  logic [3:0]  mv_mask_q;
  logic [WIDX_W-1:0] mv_base_q;
  logic [7:0]  mv_new_q [4];
  logic        err_q;

  int unsigned a_int;
  assign a_int = 32'(bus_addr);

  wire cm_sel  = (a_int >= A_CMAP0) && (a_int < A_CMAP0 + CMAP_WORDS);
  wire pin_sel = (a_int >= A_PIN0) && (a_int < A_PIN0 + PIN_WORDS);
  wire [WIDX_W-1:0] cm_widx = cm_sel ? WIDX_W'(a_int - A_CMAP0) : '0;
  wire [WIDX_W-1:0] pw_idx  = pin_sel ? WIDX_W'(a_int - A_PIN0) : '0;

  wire rej_busy = bus_wr && busy;
  wire rej_feat = bus_wr && (a_int == A_FEAT);
  wire rej_cfg  = bus_wr && (a_int == A_CFG) && cfg_q[EN_BIT] && (bus_wdata != 32'd0);
  wire reject   = rej_busy || rej_feat || rej_cfg;
  wire wr_ok    = bus_wr && !reject;
  wire cm_wr    = wr_ok && cm_sel;
  wire pin_wr   = wr_ok && pin_sel;
  wire cfg_wr   = wr_ok && (a_int == A_CFG);

  logic [7:0] dec_new [4];
  logic [3:0] fld_chg, fld_pend;
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      dec_new[i]  = cfg_q[ENC_BIT] ? bus_wdata[8*i +: 8] : low_bit_dec(bus_wdata[8*i +: 8]);
      fld_chg[i]  = dec_new[i] != core_q[{cm_widx, 2'(i)}];
      fld_pend[i] = line_pend[{cm_widx, 2'(i)}];
    end
  end

  logic [1:0] mv_sel;
  always_comb begin
    if (mv_mask_q[0])      mv_sel = 2'd0;
    else if (mv_mask_q[1]) mv_sel = 2'd1;
    else if (mv_mask_q[2]) mv_sel = 2'd2;
    else                   mv_sel = 2'd3;
  end

  assign busy     = |mv_mask_q;
  assign mv_valid = busy;
  assign mv_line  = LINE_W'({mv_base_q, mv_sel});
  assign mv_old   = core_q[mv_line];
  assign mv_new   = mv_new_q[mv_sel];
  assign bus_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      err_q     <= 1'b0;
      mv_mask_q <= '0;
      mv_base_q <= '0;
      for (int i = 0; i < 4; i++) mv_new_q[i] <= '0;
      for (int w = 0; w < CMAP_WORDS; w++) cmap_raw[w] <= '0;
      for (int p = 0; p < PIN_WORDS; p++) pin_raw[p] <= '0;
      for (int l = 0; l < N_LINES; l++) core_q[l] <= '0;
      for (int g = 0; g < GROUPS; g++) pin_q[g] <= '0;
    end else begin
      err_q <= reject;
      if (cfg_wr) cfg_q <= bus_wdata & FEATURE_MASK;
      if (pin_wr) begin
        pin_raw[pw_idx] <= bus_wdata;
        for (int g = 0; g < GROUPS; g++)
          if (pw_idx == WIDX_W'(g / 4))
            pin_q[g] <= low_bit_dec(bus_wdata[8*(g%4) +: 8])[1:0];
      end
      if (cm_wr) begin
        cmap_raw[cm_widx] <= bus_wdata;
        mv_mask_q <= fld_chg & fld_pend;
        mv_base_q <= cm_widx;
        for (int i = 0; i < 4; i++) mv_new_q[i] <= dec_new[i];
      end else if (busy) begin
        mv_mask_q <= mv_mask_q & ~(4'b1 << mv_sel);
      end
      for (int l = 0; l < N_LINES; l++) begin
        if (cm_wr && cm_widx == WIDX_W'(l / 4) && fld_chg[l%4] && !fld_pend[l%4])
          core_q[l] <= dec_new[l%4];
        else if (busy && mv_line == LINE_W'(l))
          core_q[l] <= mv_new;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (a_int == A_FEAT)     bus_rdata = FEATURE_MASK;
    else if (a_int == A_CFG) bus_rdata = cfg_q;
    else if (pin_sel)        bus_rdata = pin_raw[pw_idx];
    else if (cm_sel)         bus_rdata = cmap_raw[cm_widx];
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_core_out
    assign line_core[8*l +: 8] = core_q[l];
  end
  for (genvar g = 0; g < GROUPS; g++) begin : g_pin_out
    assign grp_pin[2*g +: 2] = pin_q[g];
  end

  // R6
  move_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !bus_wr |=> core_q[$past(mv_line)] == $past(mv_new));
  // R7
  move_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> mv_old != mv_new);
  // R8
  feat_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && a_int == A_FEAT |=> bus_err);
  // R10
  cfg_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && a_int == A_CFG && cfg_q[EN_BIT] && bus_wdata != 0 |=> bus_err && $stable(cfg_q));
  // R11
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && busy |=> bus_err && $stable(cfg_q));
  // R4
  pin_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && pin_sel && !busy |=> !busy);
endmodule

// File: tb/test_irq_route_map.sv
module test_irq_route_map;
  localparam int N_LINES = 64;
  localparam int GROUPS = 2;
  localparam int A_FEAT = 0, A_CFG = 1, A_PIN0 = 2, A_CMAP0 = 3;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_err, busy, mv_valid;
  logic [N_LINES-1:0] line_pend = '0;
  logic [N_LINES*8-1:0] line_core;
  logic [GROUPS*2-1:0] grp_pin;
  logic [5:0] mv_line;
  logic [7:0] mv_old, mv_new;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  irq_route_map i_irq_route_map (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .line_pend(line_pend), .line_core(line_core), .grp_pin(grp_pin),
    .busy(busy), .mv_valid(mv_valid), .mv_line(mv_line),
    .mv_old(mv_old), .mv_new(mv_new));

  // {encoded mode, byte, expected core}
  localparam logic [16:0] VEC [10] = '{
    {1'b0, 8'h01, 8'd0}, {1'b0, 8'h02, 8'd1}, {1'b0, 8'h04, 8'd2},
    {1'b0, 8'h08, 8'd3}, {1'b0, 8'h10, 8'd0}, {1'b0, 8'h00, 8'd0},
    {1'b0, 8'h0C, 8'd2}, {1'b0, 8'h80, 8'd0}, {1'b1, 8'h05, 8'd5},
    {1'b1, 8'hA3, 8'hA3}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 8'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 8'(a); #1; d = bus_rdata;
  endtask

  function automatic logic [7:0] core_of(input int l);
    return line_core[8*l +: 8];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A_CFG, d); chk(d == 0, "R1 cfg", d, 0);
    chk(!busy, "R1 busy", busy, 0);
    chk(line_core == '0 && grp_pin == '0, "R1 maps", {grp_pin}, 0);

    // R2 / R3 table walk on line 0
    for (int k = 0; k < 10; k++) begin
      wr(A_CFG, {30'd0, VEC[k][16], 1'b0});
      wr(A_CMAP0, {24'd0, VEC[k][15:8]});
      chk(core_of(0) == VEC[k][7:0], VEC[k][16] ? "R3 decode" : "R2 decode",
          core_of(0), VEC[k][7:0]);
    end
    wr(A_CFG, 0);
    wr(A_CMAP0, 32'h0201_0000);
    chk(core_of(2) == 0 && core_of(3) == 1, "R2 field position", core_of(3), 1);
    rd(A_CMAP0, d); chk(d == 32'h0201_0000, "R5 raw readback", d, 32'h0201_0000);

    // R4 pin map, with pending lines present
    line_pend = '1;
    wr(A_PIN0, 32'h0000_0408);
    chk(grp_pin == 4'b1011, "R4 pins", grp_pin, 4'b1011);
    chk(!busy, "R4 no move", busy, 0);
    wr(A_PIN0, 32'h0000_2000);
    chk(grp_pin == 4'b0000, "R4 fallback", grp_pin, 0);
    line_pend = '0;

    // R8 feature register
    rd(A_FEAT, d); chk(d == 32'h3, "R8 feature read", d, 3);
    wr(A_FEAT, 32'h1); chk(bus_err == 1, "R8 feature write err", bus_err, 1);

    // R9 / R10 configuration
    wr(A_CFG, 32'hFFFF_FFFC); chk(bus_err == 0, "R9 accept", bus_err, 0);
    rd(A_CFG, d); chk(d == 0, "R9 masked", d, 0);
    wr(A_CFG, 32'h1); rd(A_CFG, d); chk(d == 1, "R9 enable", d, 1);
    wr(A_CFG, 32'h3); chk(bus_err == 1, "R10 err", bus_err, 1);
    rd(A_CFG, d); chk(d == 1, "R10 unchanged", d, 1);
    wr(A_CFG, 32'h0); chk(bus_err == 0, "R10 zero ok", bus_err, 0);
    rd(A_CFG, d); chk(d == 0, "R10 cleared", d, 0);

    // R5 / R6 migration on word 1 (lines 4..7); lines 4 and 6 pending
    line_pend[4] = 1; line_pend[6] = 1;
    wr(A_CMAP0 + 1, 32'h0802_0402);
    chk(core_of(5) == 2 && core_of(7) == 3, "R5 idle lines immediate", core_of(5), 2);
    chk(busy && mv_valid && mv_line == 4 && mv_old == 0 && mv_new == 1, "R6 first move", mv_line, 4);
    chk(core_of(4) == 0, "R6 line4 not yet", core_of(4), 0);
    @(negedge clk);
    chk(core_of(4) == 1, "R6 line4 moved", core_of(4), 1);
    chk(mv_valid && mv_line == 6 && mv_old == 0 && mv_new == 1, "R6 second move", mv_line, 6);
    @(negedge clk);
    chk(!busy && core_of(6) == 1, "R6 done", core_of(6), 1);

    // R11 write while busy
    wr(A_CMAP0 + 1, 32'h0804_0401);
    chk(busy && mv_line == 4 && mv_old == 1 && mv_new == 0, "R6 reverse move", mv_old, 1);
    wr(A_CFG, 32'h2);
    chk(bus_err == 1, "R11 busy err", bus_err, 1);
    rd(A_CFG, d); chk(d == 0, "R11 cfg unchanged", d, 0);
    chk(core_of(4) == 0 && mv_line == 6 && mv_new == 2, "R6 continues", mv_line, 6);
    @(negedge clk);
    chk(!busy && core_of(6) == 2, "R6 line6 moved", core_of(6), 2);

    // R7 unchanged fields
    wr(A_CMAP0 + 1, 32'h0804_0401);
    chk(!busy, "R7 no move", busy, 0);
    chk(core_of(4) == 0 && core_of(6) == 2, "R7 cores kept", core_of(6), 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule